// File: doc/BRIEF.md
# GPIO Port Register Controller

This block is the register side of a 16-pin general-purpose I/O port. A simple synchronous 32-bit bus writes and reads a small register file. The registers hold, for each pin, a two-bit mode, a drive type, a two-bit speed, a two-bit pull setting and a four-bit alternate-function selector. They also hold the output latch and the synchronized pin levels.

From these fields the block drives registered pad controls for each pin: output enable, output value, open-drain, pull, speed and function index. In alternate-function mode a pin takes its value and enable from one of sixteen peripheral inputs, chosen by the pin's selector. A write-only set/clear register changes any subset of output latch bits in a single bus write, so no read-modify-write is needed.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, every register reads 0 (all pins input, no pull, push-pull, low speed, function 0, output latch 0). Every pad output enable is 0.
- R2: The stored configuration registers read back what was written, at these byte offsets: mode 0x00, drive type 0x04, speed 0x08, pull 0x0C, function-select pins 0–7 at 0x20, function-select pins 8–15 at 0x24.
  - Mode uses bits [2n+1:2n] for pin n, with codes 0 input, 1 output, 2 alternate, 3 analog.
  - Drive type uses bit n (0 push-pull, 1 open-drain), and its bits 31:16 read 0.
  - Speed uses [2n+1:2n].
  - Pull uses [2n+1:2n], with codes 0 none, 1 up, 2 down.
  - Function select uses [4(n mod 8)+3:4(n mod 8)].
- R3: A write to the set/clear register at 0x18 does three things to the output latch. Bit n (n<16) sets latch bit n. Bit n+16 clears latch bit n. Zero bits leave the latch alone. A read of 0x18 returns 0.
- R4: When one write both sets and clears the same pin, the pin ends up set.
- R5: The output latch at 0x14 can be written directly. Reading it returns the latch, not the pin levels.
- R6: Reading the input register at 0x10 returns the pin levels after a two-flop synchronizer. Writes to 0x10 have no effect.
- R7: For a pin in output mode with push-pull type, the pad output enable is 1 and the pad value equals the latch bit.
- R8: For a pin in output mode with open-drain type, the pad value equals the latch bit and the enable is 1 only when that bit is 0.
- R9: For a pin in alternate mode, the pad value is the peripheral value at the pin's selected index, and the enable is the peripheral enable at that index. With open-drain type, the enable is additionally masked to 0 when the value is 1.
- R10: For a pin in input or analog mode, the pad output enable is 0 whatever the latch holds.
- R11: The pad open-drain, pull, speed and function-index outputs follow the register fields of each pin one clock after the register changes.
- R12: Offsets 0x1C and above 0x24, and any address whose low two bits are not zero, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe; data valid on the following cycle |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data (0 when no read) |
| pad_in_i | input | 16 | Asynchronous pin levels |
| af_val_i | input | 256 | Peripheral values, pin n function f at bit 16n+f |
| af_en_i | input | 256 | Peripheral enables, same layout |
| pad_out_o | output | 16 | Pad output value |
| pad_oe_o | output | 16 | Pad output enable |
| pad_od_o | output | 16 | Pad open-drain select |
| pad_pull_o | output | 32 | Pull code, 2 bits per pin |
| pad_speed_o | output | 32 | Speed code, 2 bits per pin |
| pad_af_sel_o | output | 64 | Function index, 4 bits per pin |

## Verification
Some properties are checked on every cycle:
- A set/clear write leaves each requested bit set and each clear-only bit cleared.
- The latch stays unchanged when no write occurs.
- Reads of the set/clear register return 0.
- Input and analog pins never enable their driver.
- Push-pull and open-drain output pins produce the required enable.

Other behaviour needs the bench's scenarios:
- Field positions and readback masking.
- The function-selector sweep that routes each peripheral input.
- The synchronizer delay.
- The handling of unmapped and unaligned addresses.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    PM_INPUT  = 2'd0,
    PM_OUTPUT = 2'd1,
    PM_ALT    = 2'd2,
    PM_ANALOG = 2'd3
  } pin_mode_e;

  // word indices (byte offset / 4)
  localparam int IDX_MODE  = 0;
  localparam int IDX_OTYPE = 1;
  localparam int IDX_SPEED = 2;
  localparam int IDX_PULL  = 3;
  localparam int IDX_IDR   = 4;
  localparam int IDX_ODR   = 5;
  localparam int IDX_BSRR  = 6;
  localparam int IDX_AFL   = 8;
  localparam int IDX_AFH   = 9;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int N      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  logic [N-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_chain
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int N  = 16,
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic [N-1:0]    pin_sync,
  output logic [2*N-1:0]  mode_q,
  output logic [N-1:0]    otype_q,
  output logic [2*N-1:0]  speed_q,
  output logic [2*N-1:0]  pull_q,
  output logic [N-1:0]    odr_q,
  output logic [2*DW-1:0] afsel_q
);
  localparam int IW = AW - 2;
  localparam int HALF = DW / 2;

  logic [IW-1:0] widx;
  logic          aligned;
  logic          bsrr_we;
  logic [DW-1:0] rd_next;

  assign widx    = addr[AW-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign bsrr_we = wr_en && aligned && (int'(widx) == IDX_BSRR);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      otype_q <= '0;
      speed_q <= '0;
      pull_q  <= '0;
      odr_q   <= '0;
      afsel_q <= '0;
    end else if (wr_en && aligned) begin
      case (int'(widx))
        IDX_MODE:  mode_q  <= wdata[2*N-1:0];
        IDX_OTYPE: otype_q <= wdata[N-1:0];
        IDX_SPEED: speed_q <= wdata[2*N-1:0];
        IDX_PULL:  pull_q  <= wdata[2*N-1:0];
        IDX_ODR:   odr_q   <= wdata[N-1:0];
        // set bits applied after clear bits: set has priority
        IDX_BSRR:  odr_q   <= (odr_q & ~wdata[HALF +: N]) | wdata[N-1:0];
        IDX_AFL:   afsel_q[DW-1:0]    <= wdata;
        IDX_AFH:   afsel_q[2*DW-1:DW] <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_next = '0;
    if (aligned) begin
      case (int'(widx))
        IDX_MODE:  rd_next[2*N-1:0] = mode_q;
        IDX_OTYPE: rd_next[N-1:0]   = otype_q;
        IDX_SPEED: rd_next[2*N-1:0] = speed_q;
        IDX_PULL:  rd_next[2*N-1:0] = pull_q;
        IDX_IDR:   rd_next[N-1:0]   = pin_sync;
        IDX_ODR:   rd_next[N-1:0]   = odr_q;
        IDX_AFL:   rd_next          = afsel_q[DW-1:0];
        IDX_AFH:   rd_next          = afsel_q[2*DW-1:DW];
        default:   rd_next          = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_en ? rd_next : '0;
  end

  // R3
  bsrr_set_chk: assert property (@(posedge clk) disable iff (rst)
    bsrr_we |=> ((odr_q & $past(wdata[N-1:0])) == $past(wdata[N-1:0])));
  // R3
  bsrr_clr_chk: assert property (@(posedge clk) disable iff (rst)
    bsrr_we |=> ((odr_q & $past(wdata[HALF +: N]) & ~$past(wdata[N-1:0])) == '0));
  // R5
  odr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(odr_q));
  // R3
  bsrr_rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && aligned && int'(widx) == IDX_BSRR) |=> (rdata == '0));
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
  import gpio_port_pkg::*;
#(
  parameter int SW = 4,
  localparam int NAF = 1 << SW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     mode_i,
  input  logic           od_i,
  input  logic           odr_i,
  input  logic [SW-1:0]  sel_i,
  input  logic [NAF-1:0] af_val_i,
  input  logic [NAF-1:0] af_en_i,
  output logic           out_o,
  output logic           oe_o
);
  logic val_d, en_d;

  always_comb begin
    val_d = 1'b0;
    en_d  = 1'b0;
    case (pin_mode_e'(mode_i))
      PM_OUTPUT: begin
        val_d = odr_i;
        en_d  = od_i ? ~odr_i : 1'b1;
      end
      PM_ALT: begin
        val_d = af_val_i[sel_i];
        en_d  = af_en_i[sel_i] & (od_i ? ~af_val_i[sel_i] : 1'b1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_o <= 1'b0;
      oe_o  <= 1'b0;
    end else begin
      out_o <= val_d;
      oe_o  <= en_d;
    end
  end

  // R10
  idle_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == PM_INPUT || mode_i == PM_ANALOG) |=> !oe_o);
  // R7
  push_pull_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == PM_OUTPUT && !od_i) |=> (oe_o && out_o == $past(odr_i)));
  // R8
  open_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == PM_OUTPUT && od_i) |=> (oe_o == !out_o));
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int N  = 16,
  parameter int SW = 4,
  parameter int AW = 6,
  parameter int DW = 32,
  localparam int NAF = 1 << SW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr_en,
  input  logic             bus_rd_en,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [N-1:0]     pad_in_i,
  input  logic [N*NAF-1:0] af_val_i,
  input  logic [N*NAF-1:0] af_en_i,
  output logic [N-1:0]     pad_out_o,
  output logic [N-1:0]     pad_oe_o,
  output logic [N-1:0]     pad_od_o,
  output logic [2*N-1:0]   pad_pull_o,
  output logic [2*N-1:0]   pad_speed_o,
  output logic [SW*N-1:0]  pad_af_sel_o
);
  logic [N-1:0]    pin_sync;
  logic [2*N-1:0]  mode_q, speed_q, pull_q;
  logic [N-1:0]    otype_q, odr_q;
  logic [2*DW-1:0] afsel_q;

  gpio_in_sync #(.N(N), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .async_i(pad_in_i), .sync_o(pin_sync)
  );

  gpio_port_regs #(.N(N), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(bus_wr_en), .rd_en(bus_rd_en), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .pin_sync(pin_sync),
    .mode_q(mode_q), .otype_q(otype_q), .speed_q(speed_q),
    .pull_q(pull_q), .odr_q(odr_q), .afsel_q(afsel_q)
  );

  for (genvar n = 0; n < N; n++) begin : g_pin
    gpio_pin_drive #(.SW(SW)) u_drive (
      .clk(clk), .rst(rst),
      .mode_i(mode_q[2*n +: 2]),
      .od_i(otype_q[n]),
      .odr_i(odr_q[n]),
      .sel_i(afsel_q[SW*n +: SW]),
      .af_val_i(af_val_i[NAF*n +: NAF]),
      .af_en_i(af_en_i[NAF*n +: NAF]),
      .out_o(pad_out_o[n]),
      .oe_o(pad_oe_o[n])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_od_o     <= '0;
      pad_pull_o   <= '0;
      pad_speed_o  <= '0;
      pad_af_sel_o <= '0;
    end else begin
      pad_od_o     <= otype_q;
      pad_pull_o   <= pull_q;
      pad_speed_o  <= speed_q;
      pad_af_sel_o <= afsel_q[SW*N-1:0];
    end
  end
endmodule

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb;
  localparam int N = 16, SW = 4, NAF = 16, AW = 6, DW = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1;
  logic wr = 1'b0, rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [N-1:0] pad_in = '0;
  logic [N*NAF-1:0] af_val, af_en;
  logic [N-1:0] p_out, p_oe, p_od;
  logic [2*N-1:0] p_pull, p_speed;
  logic [SW*N-1:0] p_sel;

  int n_cmp = 0, n_bad = 0;

  gpio_port_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_wr_en(wr), .bus_rd_en(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .pad_in_i(pad_in),
    .af_val_i(af_val), .af_en_i(af_en), .pad_out_o(p_out), .pad_oe_o(p_oe),
    .pad_od_o(p_od), .pad_pull_o(p_pull), .pad_speed_o(p_speed),
    .pad_af_sel_o(p_sel)
  );

  task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  function automatic logic [31:0] fill2(input logic [1:0] code);
    logic [31:0] r;
    for (int n = 0; n < N; n++) r[2*n +: 2] = code;
    return r;
  endfunction

  initial begin
    for (int n = 0; n < N; n++)
      for (int f = 0; f < NAF; f++) begin
        af_val[n*NAF+f] = ((n*5 + f*3) % 4) < 2;
        af_en[n*NAF+f]  = ((n + 2*f) % 3) != 0;
      end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired (R1) actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] d, afl, afh;
    logic [15:0] exp_out, exp_oe, odr_model;
    logic [63:0] sel_all;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();

    // R1: reset state
    for (int i = 0; i < 10; i++) begin
      bus_rd(6'(4*i), d);
      cmp($sformatf("R1 reg %0d after reset", i), d, 0);
    end
    cmp("R1 pad_oe after reset", p_oe, 0);

    // R2: readback and field layout
    bus_wr(6'h00, 32'hE4E4_1B1B); bus_rd(6'h00, d); cmp("R2 mode readback", d, 32'hE4E4_1B1B);
    bus_wr(6'h04, 32'hFFFF_FFFF); bus_rd(6'h04, d); cmp("R2 otype mask", d, 32'h0000_FFFF);
    bus_wr(6'h08, 32'h1234_5678); bus_rd(6'h08, d); cmp("R2 speed readback", d, 32'h1234_5678);
    bus_wr(6'h0C, 32'h9999_6666); bus_rd(6'h0C, d); cmp("R2 pull readback", d, 32'h9999_6666);
    bus_wr(6'h20, 32'h7654_3210); bus_rd(6'h20, d); cmp("R2 afl readback", d, 32'h7654_3210);
    bus_wr(6'h24, 32'hFEDC_BA98); bus_rd(6'h24, d); cmp("R2 afh readback", d, 32'hFEDC_BA98);

    // R11: pad config outputs follow fields
    settle();
    cmp("R11 pad_od", p_od, 16'hFFFF);
    cmp("R11 pad_speed", p_speed, 32'h1234_5678);
    cmp("R11 pad_pull", p_pull, 32'h9999_6666);
    cmp("R11 pad_af_sel", p_sel, 64'hFEDC_BA98_7654_3210);
    bus_wr(6'h04, 32'h0000_0000);
    bus_wr(6'h00, 32'h0);

    // R5: ODR direct write, read returns latch not pins
    pad_in = 16'h0F0F;
    bus_wr(6'h14, 32'h0000_A5A5); bus_rd(6'h14, d);
    cmp("R5 odr readback", d, 32'h0000_A5A5);

    // R3: per-bit set then clear sweep
    bus_wr(6'h14, 32'h0);
    odr_model = '0;
    for (int k = 0; k < N; k++) begin
      bus_wr(6'h18, 32'(1) << k);
      odr_model[k] = 1'b1;
      bus_rd(6'h14, d); cmp($sformatf("R3 set bit %0d", k), d, {16'h0, odr_model});
    end
    for (int k = 0; k < N; k++) begin
      bus_wr(6'h18, 32'(1) << (k + 16));
      odr_model[k] = 1'b0;
      bus_rd(6'h14, d); cmp($sformatf("R3 clear bit %0d", k), d, {16'h0, odr_model});
    end
    bus_wr(6'h14, 32'h0000_FF00);
    bus_wr(6'h18, 32'hF000_000F);
    bus_rd(6'h14, d); cmp("R3 mixed set/clear", d, 32'h0000_0F0F);
    bus_rd(6'h18, d); cmp("R3 set/clear reads zero", d, 0);

    // R4: set wins
    bus_wr(6'h14, 32'h0);
    bus_wr(6'h18, 32'hFFFF_FFFF);
    bus_rd(6'h14, d); cmp("R4 set and clear all", d, 32'h0000_FFFF);
    bus_wr(6'h18, 32'h00F0_0000 | 32'h00F0_00F0);
    bus_rd(6'h14, d); cmp("R4 set wins on overlap", d, 32'h0000_FFFF);

    // R6: synchronized input sweep, writes ignored
    for (int k = 0; k < 8; k++) begin
      pad_in = 16'((k * 16'h2F13) ^ 16'h5A5A);
      settle(); settle();
      bus_rd(6'h10, d);
      cmp($sformatf("R6 idr pattern %0d", k), d, {16'h0, pad_in});
    end
    bus_wr(6'h10, 32'h0000_1234);
    bus_rd(6'h10, d); cmp("R6 idr write ignored", d, {16'h0, pad_in});

    // R7: push-pull output
    bus_wr(6'h14, 32'h0000_C3A5);
    bus_wr(6'h00, fill2(2'd1));
    settle();
    cmp("R7 push-pull oe", p_oe, 16'hFFFF);
    cmp("R7 push-pull out", p_out, 16'hC3A5);

    // R8: open-drain output
    bus_wr(6'h04, 32'h0000_FFFF);
    settle();
    cmp("R8 open-drain oe", p_oe, 16'h3C5A);
    cmp("R8 open-drain out", p_out, 16'hC3A5);

    // R10: input and analog never drive
    bus_wr(6'h04, 32'h0);
    bus_wr(6'h00, fill2(2'd0)); settle();
    cmp("R10 input oe", p_oe, 16'h0);
    bus_wr(6'h00, fill2(2'd3)); settle();
    cmp("R10 analog oe", p_oe, 16'h0);

    // R9: alternate-function routing sweep
    bus_wr(6'h00, fill2(2'd2));
    for (int od = 0; od < 2; od++) begin
      bus_wr(6'h04, od ? 32'h0000_FFFF : 32'h0);
      for (int s = 0; s < NAF; s++) begin
        sel_all = '0;
        for (int n = 0; n < N; n++) sel_all[4*n +: 4] = 4'((n + s) % NAF);
        afl = sel_all[31:0]; afh = sel_all[63:32];
        bus_wr(6'h20, afl); bus_wr(6'h24, afh);
        settle();
        for (int n = 0; n < N; n++) begin
          int f;
          f = (n + s) % NAF;
          exp_out[n] = af_val[n*NAF+f];
          exp_oe[n]  = af_en[n*NAF+f] & (od ? ~af_val[n*NAF+f] : 1'b1);
        end
        cmp($sformatf("R9 alt out od=%0d s=%0d", od, s), p_out, exp_out);
        cmp($sformatf("R9 alt oe od=%0d s=%0d", od, s), p_oe, exp_oe);
      end
    end

    // R12: lock / unmapped / unaligned addresses
    bus_wr(6'h14, 32'h0000_1357);
    bus_wr(6'h1C, 32'hFFFF_FFFF); bus_rd(6'h1C, d); cmp("R12 lock offset reads zero", d, 0);
    bus_wr(6'h28, 32'hFFFF_FFFF); bus_rd(6'h28, d); cmp("R12 unmapped reads zero", d, 0);
    bus_wr(6'h15, 32'h0000_FFFF); bus_rd(6'h15, d); cmp("R12 unaligned reads zero", d, 0);
    bus_rd(6'h14, d); cmp("R12 odr untouched", d, 32'h0000_1357);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule